// File: doc/BRIEF.md
# Low-Frequency Tick Counter with Overflow Extension and Compare Events

This block is a slow real-time counter for a chip's always-on domain. A single-cycle `tick_en` pulse, nominally at 32.768 kHz, drives an up-counter through a programmable divider. Every wrap of the counter increments an extension count held above it. The two together form a wide timebase that software reads as one value, so it never has to track wraps itself.

Several compare channels watch the counter. A channel fires only when the counter steps into the programmed value. It never fires just because the value already matches. Compare hits and counter wraps are latched as event flags. A compare channel can be switched on and off at run time. The wrap event is always on. One interrupt line collects every flag whose event is enabled.

Software controls the block over a write-only strobe bus (`bus_valid`, `bus_addr`, `bus_wdata`). Through it, software starts the counter, sets the divider, loads compare values, clears flags by mask, and switches compare events on or off by mask.

Top module: `lfrtc_core`

## Requirements
- R1: After reset the counter is stopped and `running` is 0. A write to address 0 with bit 0 set starts it. While it is stopped, `tick_en` has no effect on `ext_ticks`.
- R2: `ext_ticks` carries the extension count in its upper OVF_W bits and the CNT_W-bit counter (24 bits by default) in its lower bits. While the counter runs, it advances by exactly one on every (divider+1)-th `tick_en` pulse. The divider is written at address 1, bits PRE_W-1:0, and is 0 after reset.
- R3: Compare channel i (address 8+i) sets flag bit i only on the step in which the counter moves to the programmed value. Loading a value equal to the current count raises no flag until the counter steps into that value again.
- R4: When the counter steps from its all-ones value to 0, the extension count increments and flag bit NCH (the wrap flag) sets. The wrap event has no disable.
- R5: A compare write keeps only bits CNT_W-1:0 of `bus_wdata`. Higher bits are dropped.
- R6: A start write while the counter is already running is ignored. In particular, it does not restart the divider phase.
- R7: A write to address 3 enables compare event i for every set bit i. A write to address 4 disables it. A disabled channel never sets its flag.
- R8: `irq` is 1 exactly when some flag is set and its event is enabled. The wrap flag counts as always enabled.
- R9: A write to address 2 clears every flag whose bit is set in `bus_wdata`. Bit i is compare channel i and bit NCH is the wrap flag. If an event sets a flag in the same cycle as a clear, the flag stays set.
- R10: Reset zeroes the counter, the extension count, the divider, all flags and all compare enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Low-frequency tick pulse, one cycle wide |
| bus_valid | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | 32 | Write data |
| running | output | 1 | Counter has been started |
| ext_ticks | output | CNT_W+OVF_W | Extension count above the counter value |
| evt_flags | output | NCH+1 | Latched event flags; bit NCH is the wrap flag |
| irq | output | 1 | OR of all enabled flags |

## Verification
The wrap of the counter is the hardest case to reach. At the default width it needs about sixteen million steps, so the bench builds the block with a narrow counter and widens the extension count to match. A wrap then comes every thousand or so ticks, and several occur during a long randomized phase. The other hard case is a flag clear landing on the exact cycle a compare hit sets the same flag. Directed stimulus places a compare two steps ahead and issues the clear on the second tick. A behavioural model then follows every cycle of randomized ticks, divider changes, restarts and mask writes.

// File: rtl/lfrtc_core.sv
module lfrtc_core #(
  parameter int CNT_W  = 24,
  parameter int OVF_W  = 8,
  parameter int NCH    = 4,
  parameter int PRE_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_en,
  input  logic                   bus_valid,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic                   running,
  output logic [CNT_W+OVF_W-1:0] ext_ticks,
  output logic [NCH:0]           evt_flags,
  output logic                   irq
);
  localparam int EXT_W   = CNT_W + OVF_W;
  localparam int NEV     = NCH + 1;
  localparam int A_START = 0;
  localparam int A_DIV   = 1;
  localparam int A_CLR   = 2;
  localparam int A_EN    = 3;
  localparam int A_DIS   = 4;
  localparam int A_CMP0  = 8;

  logic             run_q;
  logic [PRE_W-1:0] div_q, ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OVF_W-1:0] ovf_q;
  logic [NCH-1:0]   en_q, hit, cmp_wr;
  logic [NEV-1:0]   flag_q, set_v, clr_v;
  logic [CNT_W-1:0] cmp_q [NCH];

  wire wr_start = bus_valid && bus_addr == ADDR_W'(A_START) && bus_wdata[0];
  wire wr_div   = bus_valid && bus_addr == ADDR_W'(A_DIV);
  wire wr_en    = bus_valid && bus_addr == ADDR_W'(A_EN);
  wire wr_dis   = bus_valid && bus_addr == ADDR_W'(A_DIS);
  wire step     = run_q && tick_en && (ph_q >= div_q);
  wire at_max   = &cnt_q;
  wire [CNT_W-1:0] cnt_nx = cnt_q + 1'b1;

  assign clr_v = (bus_valid && bus_addr == ADDR_W'(A_CLR)) ? bus_wdata[NEV-1:0] : '0;
  assign set_v = {step && at_max, hit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
      ovf_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_start && !run_q) begin
        run_q <= 1'b1;
        ph_q  <= '0;
      end else if (run_q && tick_en) begin
        ph_q <= (ph_q >= div_q) ? '0 : ph_q + 1'b1;
      end
      if (wr_div) div_q <= bus_wdata[PRE_W-1:0];
      if (step) begin
        cnt_q <= cnt_nx;
        if (at_max) ovf_q <= ovf_q + 1'b1;
      end
      flag_q <= set_v | (flag_q & ~clr_v);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cmp_wr[i] = bus_valid && bus_addr == ADDR_W'(A_CMP0 + i);
    assign hit[i]    = step && en_q[i] && (cnt_nx == cmp_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q[i] <= '0;
        en_q[i]  <= 1'b0;
      end else begin
        if (cmp_wr[i]) cmp_q[i] <= bus_wdata[CNT_W-1:0];
        if (wr_dis && bus_wdata[i])     en_q[i] <= 1'b0;
        else if (wr_en && bus_wdata[i]) en_q[i] <= 1'b1;
      end
    end

    AST_CMP_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flag_q[i]) && !$past(cmp_wr[i])) |-> (cnt_q == cmp_q[i] && cnt_q != $past(cnt_q))); // R3
    AST_CMP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[i] && !flag_q[i]) |=> !flag_q[i]); // R7
  end

  assign running   = run_q;
  assign ext_ticks = {ovf_q, cnt_q};
  assign evt_flags = flag_q;
  assign irq       = |(flag_q & {1'b1, en_q});

  AST_HALTED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(ext_ticks)); // R1
  AST_EXT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    EXT_W'(ext_ticks - $past(ext_ticks)) <= EXT_W'(1)); // R2
  AST_WRAP_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[NCH]) |-> (cnt_q == '0 && ovf_q != $past(ovf_q))); // R4
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flag_q) |-> !irq); // R8
endmodule

// File: tb/lfrtc_core_tb_top.sv
module lfrtc_core_tb_top;
  localparam int CW = 10, OW = 22, NC = 4, PW = 4, AW = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, tick = 0, bv = 0;
  logic [AW-1:0] ba = '0;
  logic [31:0] bd = '0;
  logic running, irq;
  logic [CW+OW-1:0] ext;
  logic [NC:0] flags;

  lfrtc_core #(.CNT_W(CW), .OVF_W(OW), .NCH(NC), .PRE_W(PW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick), .bus_valid(bv), .bus_addr(ba),
    .bus_wdata(bd), .running(running), .ext_ticks(ext), .evt_flags(flags), .irq(irq));

  always #10 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  int m_cnt = 0, m_ovf = 0, m_ph = 0, m_div = 0;
  bit m_run = 0;
  int m_cmp [NC];
  bit m_en [NC];
  bit [NC:0] m_fl = '0;

  task automatic chk(string req, longint got, longint exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic void model();
    bit stp = m_run && tick && (m_ph >= m_div);
    int nc = stp ? ((m_cnt == MAXC) ? 0 : m_cnt + 1) : m_cnt;
    bit [NC:0] setv = '0;
    bit [NC:0] clrv = (bv && ba == 2) ? bd[NC:0] : '0;
    for (int i = 0; i < NC; i++) setv[i] = stp && m_en[i] && (nc == m_cmp[i]);
    setv[NC] = stp && (m_cnt == MAXC);
    m_fl = setv | (m_fl & ~clrv);
    if (setv[NC]) m_ovf++;
    m_cnt = nc;
    if (!m_run && bv && ba == 0 && bd[0]) begin m_run = 1; m_ph = 0; end
    else if (m_run && tick) m_ph = (m_ph >= m_div) ? 0 : m_ph + 1;
    if (bv && ba == 1) m_div = int'(bd[PW-1:0]);
    for (int i = 0; i < NC; i++) begin
      if (bv && ba == AW'(8 + i)) m_cmp[i] = int'(bd[CW-1:0]);
      if (bv && ba == 4 && bd[i]) m_en[i] = 0;
      else if (bv && ba == 3 && bd[i]) m_en[i] = 1;
    end
  endfunction

  task automatic cyc();
    bit ei;
    @(posedge clk);
    model();
    @(negedge clk);
    ei = m_fl[NC];
    for (int i = 0; i < NC; i++) ei |= m_fl[i] & m_en[i];
    chk("R2 ext_ticks", ext, (longint'(m_ovf) << CW) | m_cnt);
    chk("R3 R4 R9 evt_flags", flags, m_fl);
    chk("R1 R6 running", running, m_run);
    chk("R8 irq", irq, ei);
  endtask

  task automatic wr(int a, logic [31:0] d, bit t = 0);
    bv = 1; ba = AW'(a); bd = d; tick = t;
    cyc();
    bv = 0; tick = 0;
  endtask

  task automatic idle(int n, bit t);
    tick = t;
    for (int k = 0; k < n; k++) cyc();
    tick = 0;
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin m_cmp[i] = 0; m_en[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ext after reset", ext, 0);
    chk("R10 flags after reset", flags, 0);
    chk("R10 irq after reset", irq, 0);
    chk("R1 stopped after reset", running, 0);
    idle(8, 1);
    chk("R1 ticks ignored while stopped", ext, 0);

    wr(3, 32'h3);
    wr(8, 32'hFFFF_FC05);
    wr(0, 32'h1);
    idle(10, 1);
    chk("R5 truncated compare fired", flags[0], 1);
    chk("R8 irq on enabled flag", irq, 1);
    wr(2, 32'h1);
    chk("R9 clear by mask", flags[0], 0);

    wr(9, 32'(m_cnt));
    idle(3, 0);
    chk("R3 equal compare write silent", flags[1], 0);

    wr(1, 32'h3);
    idle(6, 1);
    wr(0, 32'h1, 1);
    idle(9, 1);
    chk("R6 restart ignored, divider phase kept", ext, m_cnt);
    wr(1, 32'h0);

    wr(4, 32'h1);
    wr(8, 32'((m_cnt + 3) & MAXC));
    idle(6, 1);
    chk("R7 disabled channel silent", flags[0], 0);

    wr(3, 32'h4);
    wr(10, 32'((m_cnt + 2) & MAXC));
    idle(1, 1);
    wr(2, 32'h4, 1);
    chk("R9 coincident set wins", flags[2], 1);
    wr(2, 32'h1F);
    chk("R9 all cleared", flags, 0);

    wr(4, 32'hF);
    while (m_cnt != 0) idle(1, 1);
    chk("R4 wrap flag set", flags[NC], 1);
    chk("R4 extension incremented", ext >> CW, 1);
    chk("R8 wrap always enabled", irq, 1);
    wr(2, 32'h10);

    for (int k = 0; k < 30000; k++) begin
      int r = $urandom_range(0, 15);
      tick = $urandom_range(0, 1);
      if (r < 2) begin
        int a = $urandom_range(0, 8);
        bv = 1; ba = AW'((a > 4) ? a + 3 : a); bd = $urandom();
      end
      cyc();
      bv = 0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule